// File: doc/BRIEF.md
# Pipelined Unrounded Floating-Point Multiplier

This block multiplies two binary floating-point operands of one width (single or double precision by default parameter choice) and delivers the exact, unrounded product in an expanded form meant for a later normalise-and-round stage. The output word holds the product sign, a widened two's-complement exponent, and a significand twice as wide as an input significand with its hidden bit. The top two significand bits are integer bits, so a finite product lies in [0, 4) before normalisation.

Subnormal operands are multiplied exactly: a hidden bit of zero and the smallest exponent stand in for them. Zero, infinity and NaN operands are recognised and mapped to fixed output codes, so the downstream stage can tell specials from finite values without extra flags. The pipeline takes a new operand pair on every enabled clock. A three-bit rounding-mode code rides alongside each pair untouched, so the rounder receives the mode that belongs to the product it sees.

Top module: `fmul_unrounded`

## Requirements
- R1: A pair sampled at an enabled rising edge produces its result at the output after the fourth following enabled edge (five enabled edges in total), and a new pair is accepted on every enabled edge.
- R2: Output layout from the most significant bit: one sign bit, an exponent of EXP_W+2 bits, then a significand of 2*(FRAC_W+1) bits. For two finite nonzero operands the sign is the XOR of the operand signs, the exponent is the two's-complement value ea+eb-bias, and the significand is the exact integer product of the two significands with their hidden bits.
- R3: An operand whose exponent field is zero and fraction nonzero is treated as having hidden bit 0 and effective exponent 1.
- R4: When an operand is zero (exponent and fraction fields all zero) and no NaN result applies and neither operand is infinite, the exponent and significand fields are all zero and the sign is the XOR of the operand signs.
- R5: When an operand is infinite (exponent all ones, fraction zero) and no NaN result applies, the exponent field is 2^(EXP_W+1)-1, the significand is binary 01 followed by zeros, and the sign is the XOR of the operand signs.
- R6: When an operand is a NaN (exponent all ones, fraction nonzero), or one operand is infinite and the other zero, the output has sign 0, exponent field 2^(EXP_W+1)-1, and significand binary 011 followed by zeros.
- R7: While the clock enable is low every pipeline stage, and so both outputs, holds its value; held pairs continue unchanged when the enable returns.
- R8: A low reset at a rising edge clears the whole pipeline, making the product output and the mode output all zeros, whether or not the enable is high.
- R9: The rounding-mode input appears unchanged on the mode output with the same latency as the product it accompanies.
- R10: The total width parameter sets the exponent width (8 bits for 32, 11 bits for 64) and both widths obey R1 to R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable for every pipeline stage |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| rmode_i | input | 3 | Rounding-mode code (000 = nearest even), not interpreted here |
| prod_o | output | 1+(EXP_W+2)+2*(FRAC_W+1) | Sign, widened exponent, unrounded double-width significand |
| rmode_o | output | 3 | Rounding-mode code aligned with prod_o |

## Verification
The hardest case to reach from the ports is a pipeline that holds partially filled while the enable is low and then resumes, since an operand pair must sit in an early stage while the inputs change underneath it. The stimulus loads one pair, drops the enable for three cycles while driving a different pair and mode, then raises it again and checks that the held pair arrives first and the new pair one cycle later. Operand classes are also streamed back to back with no gaps, so any stage that mixes a neighbour's data or shifts the latency changes a compared result.

// File: rtl/fmul_pkg.sv
// Shared definitions for the unrounded multiplier pipeline.
// Assumes IEEE-754 style encodings: sign, biased exponent, fraction.
package fmul_pkg;

    // Operand / result classification carried down the pipeline.
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_FIN  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fclass_t;

    // Exponent field width for a given total operand width.
    function automatic int exp_width(input int total);
        case (total)
            16:      return 5;
            32:      return 8;
            64:      return 11;
            128:     return 15;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/fmul_unpack.sv
// Splits one operand into sign, class, effective exponent and significand.
// Subnormals get a zero hidden bit and an effective exponent of one.
// Purely combinational; the caller registers the results.
module fmul_unpack #(
    parameter  int W      = 32,
    parameter  int EXP_W  = 8,
    localparam int FRAC_W = W - 1 - EXP_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [W-1:0]       op,
    output logic               sign,
    output fmul_pkg::fclass_t  cls,
    output logic [EXP_W-1:0]   eff_exp,
    output logic [SIG_W-1:0]   sig
);
    import fmul_pkg::*;

    logic [EXP_W-1:0]  exp_fld;
    logic [FRAC_W-1:0] frac_fld;
    logic              exp_zero;
    logic              exp_ones;

    assign sign     = op[W-1];
    assign exp_fld  = op[W-2:FRAC_W];
    assign frac_fld = op[FRAC_W-1:0];
    assign exp_zero = (exp_fld == '0);
    assign exp_ones = (exp_fld == '1);

    // Decide which of the four value classes the operand belongs to.
    always_comb begin
        if (exp_ones)
            cls = (frac_fld != '0) ? CLS_NAN : CLS_INF;
        else if (exp_zero && (frac_fld == '0))
            cls = CLS_ZERO;
        else
            cls = CLS_FIN;
    end

    // Subnormals read as exponent 1 with no hidden bit.
    always_comb begin
        eff_exp = exp_zero ? EXP_W'(1) : exp_fld;
        sig     = {~exp_zero, frac_fld};
    end

endmodule

// File: rtl/fmul_sigmult.sv
// Two-stage significand multiplier: stage one forms two partial products
// by splitting the second factor, stage two adds them. Exact, no rounding.
// Assumes the inputs are already registered by the caller.
module fmul_sigmult #(
    parameter  int SIG_W   = 24,
    localparam int LO_W    = SIG_W / 2,
    localparam int HI_W    = SIG_W - LO_W,
    localparam int PP_LO_W = SIG_W + LO_W,
    localparam int PP_HI_W = SIG_W + HI_W,
    localparam int PROD_W  = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] prod
);

    logic [PP_LO_W-1:0] pp_lo_q;
    logic [PP_HI_W-1:0] pp_hi_q;
    logic [PROD_W-1:0]  prod_q;

    // Stage one: low and high partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pp_lo_q <= '0;
            pp_hi_q <= '0;
        end else if (ce) begin
            pp_lo_q <= PP_LO_W'(sig_a) * PP_LO_W'(sig_b[LO_W-1:0]);
            pp_hi_q <= PP_HI_W'(sig_a) * PP_HI_W'(sig_b[SIG_W-1:LO_W]);
        end
    end

    // Stage two: align the high part and sum into the full product.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else if (ce)
            prod_q <= PROD_W'(pp_lo_q) + (PROD_W'(pp_hi_q) << LO_W);
    end

    assign prod = prod_q;

    // R2: after two enabled edges the sum equals the full product of the inputs.
    p_exact_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ce, 1) && $past(ce, 2) && $past(rst_n, 1) && $past(rst_n, 2))
        |-> (prod_q == (PROD_W'($past(sig_a, 2)) * PROD_W'($past(sig_b, 2)))));

endmodule

// File: rtl/fmul_delay.sv
// Enable-gated delay line of DEPTH registers for sideband data that must
// stay aligned with the multiplier stages. Requires DEPTH >= 1.
module fmul_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] tap_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tap
        if (gi == 0) begin : g_first
            // First tap samples the input.
            always_ff @(posedge clk) begin
                if (!rst_n)  tap_q[gi] <= '0;
                else if (ce) tap_q[gi] <= din;
            end
        end else begin : g_next
            // Later taps shift from the previous tap.
            always_ff @(posedge clk) begin
                if (!rst_n)  tap_q[gi] <= '0;
                else if (ce) tap_q[gi] <= tap_q[gi-1];
            end
        end
    end

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/fmul_unrounded.sv
// Five-stage floating-point multiplier producing an unnormalised, unrounded
// product: sign, exponent widened by two bits, double-width significand with
// two integer bits. Stages: operand capture, unpack and exponent add, partial
// products, product sum, special-value merge. Assumes a downstream unit
// normalises and rounds using the mode code passed alongside.
module fmul_unrounded #(
    parameter  int W        = 32,
    localparam int EXP_W    = fmul_pkg::exp_width(W),
    localparam int FRAC_W   = W - 1 - EXP_W,
    localparam int SIG_W    = FRAC_W + 1,
    localparam int PROD_W   = 2 * SIG_W,
    localparam int XE_W     = EXP_W + 2,
    localparam int OUT_W    = 1 + XE_W + PROD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [2:0]       rmode_i,
    output logic [OUT_W-1:0] prod_o,
    output logic [2:0]       rmode_o
);
    import fmul_pkg::*;

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [XE_W-1:0]   SPEC_EXP = {1'b0, {(XE_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] INF_SIG  = {2'b01, {(PROD_W-2){1'b0}}};
    localparam logic [PROD_W-1:0] NAN_SIG  = {3'b011, {(PROD_W-3){1'b0}}};

    typedef struct packed {
        logic [2:0]      rm;
        logic            sign;
        fclass_t         cls;
        logic [XE_W-1:0] exp;
    } side_t;
    localparam int SIDE_W = $bits(side_t);

    // ---------------- stage 1: operand capture ----------------
    logic [W-1:0] op_q [2];
    logic [2:0]   rm_s1;

    // Register both operands and the mode code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q[0] <= '0;
            op_q[1] <= '0;
            rm_s1   <= '0;
        end else if (ce) begin
            op_q[0] <= op_a;
            op_q[1] <= op_b;
            rm_s1   <= rmode_i;
        end
    end

    // ---------------- stage 2: unpack, classify, add exponents ----------------
    logic             u_sign [2];
    fclass_t          u_cls  [2];
    logic [EXP_W-1:0] u_exp  [2];
    logic [SIG_W-1:0] u_sig  [2];

    for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
        fmul_unpack #(.W(W), .EXP_W(EXP_W)) u_unpack (
            .op      (op_q[gi]),
            .sign    (u_sign[gi]),
            .cls     (u_cls[gi]),
            .eff_exp (u_exp[gi]),
            .sig     (u_sig[gi])
        );
    end

    fclass_t                res_cls;
    logic signed [XE_W-1:0] exp_sum;

    // Resolve the result class from the two operand classes.
    always_comb begin
        if ((u_cls[0] == CLS_NAN) || (u_cls[1] == CLS_NAN) ||
            ((u_cls[0] == CLS_INF) && (u_cls[1] == CLS_ZERO)) ||
            ((u_cls[0] == CLS_ZERO) && (u_cls[1] == CLS_INF)))
            res_cls = CLS_NAN;
        else if ((u_cls[0] == CLS_INF) || (u_cls[1] == CLS_INF))
            res_cls = CLS_INF;
        else if ((u_cls[0] == CLS_ZERO) || (u_cls[1] == CLS_ZERO))
            res_cls = CLS_ZERO;
        else
            res_cls = CLS_FIN;
    end

    // Add the effective exponents and remove one bias, in widened signed form.
    always_comb begin
        exp_sum = $signed({2'b00, u_exp[0]}) + $signed({2'b00, u_exp[1]})
                - $signed(XE_W'(BIAS));
    end

    side_t            side_s2;
    logic [SIG_W-1:0] sig_a_s2;
    logic [SIG_W-1:0] sig_b_s2;

    // Register the sideband and the two significands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_s2  <= '0;
            sig_a_s2 <= '0;
            sig_b_s2 <= '0;
        end else if (ce) begin
            side_s2.rm   <= rm_s1;
            side_s2.sign <= u_sign[0] ^ u_sign[1];
            side_s2.cls  <= res_cls;
            side_s2.exp  <= exp_sum;
            sig_a_s2     <= u_sig[0];
            sig_b_s2     <= u_sig[1];
        end
    end

    // ---------------- stages 3-4: product and aligned sideband ----------------
    logic [PROD_W-1:0] prod_s4;
    logic [SIDE_W-1:0] side_s4_bits;
    side_t             side_s4;

    fmul_sigmult #(.SIG_W(SIG_W)) u_sigmult (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .sig_a (sig_a_s2),
        .sig_b (sig_b_s2),
        .prod  (prod_s4)
    );

    fmul_delay #(.WIDTH(SIDE_W), .DEPTH(2)) u_side_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .din   (side_s2),
        .dout  (side_s4_bits)
    );

    assign side_s4 = side_t'(side_s4_bits);

    // ---------------- stage 5: special-value merge ----------------
    logic [OUT_W-1:0] out_q;
    logic [2:0]       rm_q;

    // Replace the product by the fixed code of its class where needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            rm_q  <= '0;
        end else if (ce) begin
            rm_q <= side_s4.rm;
            case (side_s4.cls)
                CLS_ZERO: out_q <= {side_s4.sign, {XE_W{1'b0}}, {PROD_W{1'b0}}};
                CLS_FIN:  out_q <= {side_s4.sign, side_s4.exp, prod_s4};
                CLS_INF:  out_q <= {side_s4.sign, SPEC_EXP, INF_SIG};
                default:  out_q <= {1'b0, SPEC_EXP, NAN_SIG};
            endcase
        end
    end

    assign prod_o  = out_q;
    assign rmode_o = rm_q;

    // ---------------- port-level checks ----------------
    // Count consecutive enabled edges since reset, saturating at five.
    logic [2:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_cnt <= '0;
        else if (!ce)     run_cnt <= '0;
        else if (run_cnt != 3'd5) run_cnt <= run_cnt + 3'd1;
    end

    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic in_nan, in_zero_res, out_is_nan;
    assign a_nan  = (op_a[W-2:FRAC_W] == '1) && (op_a[FRAC_W-1:0] != '0);
    assign b_nan  = (op_b[W-2:FRAC_W] == '1) && (op_b[FRAC_W-1:0] != '0);
    assign a_inf  = (op_a[W-2:FRAC_W] == '1) && (op_a[FRAC_W-1:0] == '0);
    assign b_inf  = (op_b[W-2:FRAC_W] == '1) && (op_b[FRAC_W-1:0] == '0);
    assign a_zero = (op_a[W-2:0] == '0);
    assign b_zero = (op_b[W-2:0] == '0);
    assign in_nan = a_nan || b_nan || (a_inf && b_zero) || (a_zero && b_inf);
    assign in_zero_res = (a_zero || b_zero) && !in_nan && !a_inf && !b_inf;
    assign out_is_nan  = (prod_o[OUT_W-2:PROD_W] == SPEC_EXP) && prod_o[PROD_W-3];

    // R7: a disabled edge leaves the outputs as they were.
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ce) |=> ($stable(prod_o) && $stable(rmode_o)));

    // R9: the mode code leaves five enabled edges after it entered.
    p_rmode_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 3'd5) |-> (rmode_o == $past(rmode_i, 5)));

    // R2: non-NaN results carry the XOR of the operand signs.
    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt == 3'd5) && !out_is_nan)
        |-> (prod_o[OUT_W-1] == $past(op_a[W-1] ^ op_b[W-1], 5)));

    // R4: a zero operand with finite partner gives all-zero magnitude fields.
    p_zero_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt == 3'd5) && $past(in_zero_res, 5))
        |-> (prod_o[OUT_W-2:0] == '0));

    // R6: NaN inputs or infinity times zero give the canonical NaN code.
    p_nan_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_cnt == 3'd5) && $past(in_nan, 5))
        |-> (prod_o == {1'b0, SPEC_EXP, NAN_SIG}));

endmodule

// File: tb/tb_fmul_unrounded.sv
`timescale 1ns / 1ps
// Bench: a vector table streamed back to back through a 32-bit and a 64-bit
// instance, compared with a behavioural reference, then directed tests for
// reset, clock-enable hold and reset priority.
module tb_fmul_unrounded;

    localparam int N = 18;

    localparam logic [31:0] A32 [N] = '{
        32'h3F800000, 32'h3FC00000, 32'hC0400000, 32'h7F7FFFFF, 32'h00800000,
        32'h00000001, 32'h007FFFFF, 32'h00000000, 32'h80000000, 32'h7F800000,
        32'h7F800000, 32'h7F800000, 32'h7FC00000, 32'hBF800000, 32'h00000000,
        32'h3FFFFFFF, 32'h80000001, 32'h00000000};
    localparam logic [31:0] B32 [N] = '{
        32'h3F800000, 32'h40000000, 32'h40E00000, 32'h7F7FFFFF, 32'h00800000,
        32'h3F800000, 32'h007FFFFF, 32'h40A00000, 32'h40400000, 32'h40000000,
        32'hFF800000, 32'h00000000, 32'h3F800000, 32'h7F800001, 32'h00400000,
        32'hBFFFFFFF, 32'hFF800000, 32'h80000000};
    localparam logic [63:0] A64 [N] = '{
        64'h3FF0000000000000, 64'h3FF8000000000000, 64'hC008000000000000,
        64'h7FEFFFFFFFFFFFFF, 64'h0010000000000000, 64'h0000000000000001,
        64'h000FFFFFFFFFFFFF, 64'h0000000000000000, 64'h8000000000000000,
        64'h7FF0000000000000, 64'h7FF0000000000000, 64'h0000000000000000,
        64'h7FF8000000000000, 64'hBFF0000000000000, 64'h0000000000000000,
        64'h3FFFFFFFFFFFFFFF, 64'h8000000000000001, 64'h0000000000000000};
    localparam logic [63:0] B64 [N] = '{
        64'h3FF0000000000000, 64'h4000000000000000, 64'h401C000000000000,
        64'h7FEFFFFFFFFFFFFF, 64'h0010000000000000, 64'h3FF0000000000000,
        64'h000FFFFFFFFFFFFF, 64'h4014000000000000, 64'h4008000000000000,
        64'h4000000000000000, 64'hFFF0000000000000, 64'h7FF0000000000000,
        64'h3FF0000000000000, 64'h7FF0000000000001, 64'h0008000000000000,
        64'hBFFFFFFFFFFFFFFF, 64'hFFF0000000000000, 64'h8000000000000000};

    logic         clk;
    logic         rst_n;
    logic         ce;
    logic [31:0]  a32, b32;
    logic [63:0]  a64, b64;
    logic [2:0]   rm_in;
    logic [58:0]  prod32;
    logic [119:0] prod64;
    logic [2:0]   rm32, rm64;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 0;

    fmul_unrounded #(.W(32)) dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .op_a(a32), .op_b(b32),
        .rmode_i(rm_in), .prod_o(prod32), .rmode_o(rm32));

    fmul_unrounded #(.W(64)) dut_d (
        .clk(clk), .rst_n(rst_n), .ce(ce), .op_a(a64), .op_b(b64),
        .rmode_i(rm_in), .prod_o(prod64), .rmode_o(rm64));

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Behavioural reference following the requirements, any width up to 64.
    function automatic logic [127:0] ref_mul(logic [63:0] a, logic [63:0] b, int ew, int w);
        int fw, sw, pw, xw, bias, e;
        logic [63:0] emax, fmask, ea, eb, fa, fb;
        logic sa, sb, sgn, na, nb, ia, ib, za, zb;
        logic [127:0] spec, ma, mb, ev, r;
        logic signed [127:0] es;
        fw = w - 1 - ew; sw = fw + 1; pw = 2 * sw; xw = ew + 2;
        bias = (1 << (ew - 1)) - 1;
        emax = (64'd1 << ew) - 1;
        fmask = (64'd1 << fw) - 1;
        ea = (a >> fw) & emax; eb = (b >> fw) & emax;
        fa = a & fmask;        fb = b & fmask;
        sa = a[w-1]; sb = b[w-1]; sgn = sa ^ sb;
        na = (ea == emax) && (fa != 0); nb = (eb == emax) && (fb != 0);
        ia = (ea == emax) && (fa == 0); ib = (eb == emax) && (fb == 0);
        za = (ea == 0) && (fa == 0);    zb = (eb == 0) && (fb == 0);
        spec = (128'd1 << (ew + 1)) - 1;
        if (na || nb || (ia && zb) || (za && ib))
            r = (spec << pw) | (128'd3 << (pw - 3));
        else if (ia || ib)
            r = (128'(sgn) << (xw + pw)) | (spec << pw) | (128'd1 << (pw - 2));
        else if (za || zb)
            r = 128'(sgn) << (xw + pw);
        else begin
            ma = 128'(fa) | ((ea != 0) ? (128'd1 << fw) : 128'd0);
            mb = 128'(fb) | ((eb != 0) ? (128'd1 << fw) : 128'd0);
            e  = ((ea == 0) ? 1 : int'(ea)) + ((eb == 0) ? 1 : int'(eb)) - bias;
            es = e;
            ev = 128'(es) & ((128'd1 << xw) - 1);
            r  = (128'(sgn) << (xw + pw)) | (ev << pw) | (ma * mb);
        end
        return r;
    endfunction

    // Requirement tag chosen from the expected class of a vector.
    function automatic string tag_of(logic [127:0] ev, logic [63:0] a, logic [63:0] b, int ew, int w);
        int fw, pw, xw;
        logic [127:0] efld, spec;
        fw = w - 1 - ew; pw = 2 * (fw + 1); xw = ew + 2;
        spec = (128'd1 << (ew + 1)) - 1;
        efld = (ev >> pw) & ((128'd1 << xw) - 1);
        if (efld == spec) return ev[pw-3] ? "R6" : "R5";
        if ((ev & ((128'd1 << (xw + pw)) - 1)) == 0) return "R4";
        if ((((a >> fw) & ((64'd1 << ew) - 1)) == 0) || (((b >> fw) & ((64'd1 << ew) - 1)) == 0))
            return "R3";
        return "R2";
    endfunction

    task automatic check(string req, logic [127:0] got, logic [127:0] expv);
        n_checks++;
        if (got !== expv) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic drive(logic [31:0] xa, logic [31:0] xb, logic [63:0] ya, logic [63:0] yb, logic [2:0] m);
        a32 = xa; b32 = xb; a64 = ya; b64 = yb; rm_in = m;
    endtask

    // Watchdog: a hung run ends as a failure and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [127:0] e32, e64, ex, ey;
        logic [58:0]  snap;
        logic [2:0]   snap_rm;
        rst_n = 1'b0; ce = 1'b1;
        drive(32'h40400000, 32'h40400000, 64'h4008000000000000, 64'h4008000000000000, 3'd5);
        repeat (3) @(negedge clk);
        // R8: reset leaves all-zero outputs even with live inputs.
        check("R8", 128'(prod32), 128'd0);
        check("R8", 128'(rm32), 128'd0);
        check("R8", 128'(prod64), 128'd0);
        rst_n = 1'b1;

        // R1: stream one pair per cycle; result of pair j seen five edges later.
        for (int i = 0; i < N + 5; i++) begin
            if (i >= 5) begin
                e32 = ref_mul({32'd0, A32[i-5]}, {32'd0, B32[i-5]}, 8, 32);
                e64 = ref_mul(A64[i-5], B64[i-5], 11, 64);
                check({"R1/", tag_of(e32, {32'd0, A32[i-5]}, {32'd0, B32[i-5]}, 8, 32)},
                      128'(prod32), e32);
                check("R9", 128'(rm32), 128'((i - 5) % 8));
                check({"R10/", tag_of(e64, A64[i-5], B64[i-5], 11, 64)}, 128'(prod64), e64);
                check("R10/R9", 128'(rm64), 128'((i - 5) % 8));
            end
            if (i < N) drive(A32[i], B32[i], A64[i], B64[i], 3'(i % 8));
            else       drive('0, '0, '0, '0, 3'd0);
            @(negedge clk);
        end

        // R7: load one pair, hold the pipe three cycles while inputs change.
        ex = ref_mul({32'd0, A32[1]}, {32'd0, B32[1]}, 8, 32);
        ey = ref_mul({32'd0, A32[2]}, {32'd0, B32[2]}, 8, 32);
        drive(A32[1], B32[1], '0, '0, 3'd3);
        @(negedge clk);
        ce = 1'b0;
        drive(A32[2], B32[2], '0, '0, 3'd6);
        snap = prod32; snap_rm = rm32;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R7", 128'(prod32), 128'(snap));
            check("R7", 128'(rm32), 128'(snap_rm));
        end
        ce = 1'b1;
        @(negedge clk);
        drive('0, '0, '0, '0, 3'd0);
        repeat (3) @(negedge clk);
        check("R7", 128'(prod32), ex);
        check("R9", 128'(rm32), 128'd3);
        @(negedge clk);
        check("R7", 128'(prod32), ey);
        check("R9", 128'(rm32), 128'd6);

        // R8: reset wins over a low enable.
        ce = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R8", 128'(prod32), 128'd0);
        check("R8", 128'(rm32), 128'd0);
        check("R8", 128'(prod64), 128'd0);
        rst_n = 1'b1; ce = 1'b1;

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule